// File: doc/BRIEF.md
# Dual-Lane Bus Parity Generator with Role-Aware Drive Control

This block produces the two even-parity bits that accompany a 64-bit multiplexed address/data bus. One bit covers the low 32-bit lane and its four command/byte-enable bits. The other covers the high lane and its four command/byte-enable bits. Each parity bit is registered, so it shows up one clock after the address or data it protects, which is the timing the bus expects.

A small phase tracker decides when each parity pin is actually driven. Its inputs are the cycle-start strobe, the two ready handshakes, the bus role and the transfer direction. A bus master drives parity for the cycle after its address phase and for its write data phases. A target drives parity only for its read data phases. When the 32-bit strap is set, the high-lane parity pin is never driven. At every other time both enables are low and the pins float.

The phase tracker has three states:
- `ST_IDLE`: no transaction is active.
- `ST_BURST`: a transaction is active and the start strobe is still asserted.
- `ST_FINAL`: the start strobe has been released and the last data phase is still outstanding.

The transitions between them are:
- `ST_IDLE` to `ST_BURST` on an address phase.
- `ST_BURST` to `ST_FINAL` when the strobe is released without completion.
- `ST_BURST` to `ST_IDLE` when the strobe is released on the completing cycle.
- `ST_FINAL` to `ST_IDLE` on completion, or when the initiator's ready is deasserted.

Top module: `bus_parity_gen`

## Requirements
- R1: `par` at every clock equals the XOR of `ad[31:0]` and `cbe_n[3:0]` from the previous clock, so the 37 bits have an even count of ones.
- R2: `par64` at every clock equals the XOR of `ad[63:32]` and `cbe_n[7:4]` from the previous clock.
- R3: An address phase is a clock in `ST_IDLE` with `frame_n` = 0. If `is_master` = 1 in that clock, `par_oe` is 1 in the next clock.
- R4: In `ST_BURST`/`ST_FINAL`, with `is_master` = 1 and `is_write` = 1, each clock with `irdy_n` = 0 makes `par_oe` 1 in the next clock. This holds the parity valid through one clock after the phase completes (`irdy_n` = 0 and `trdy_n` = 0).
- R5: In `ST_BURST`/`ST_FINAL`, with `is_master` = 0 and `is_write` = 0, each clock with `trdy_n` = 0 makes `par_oe` 1 in the next clock.
- R6: In all other cases `par_oe` is 0 in the next clock. These cases are: a target during an address phase, a target during write data, a master during read data, and an idle bus.
- R7: With `mode32` = 1 in a clock, `par64_oe` is 0 in the next clock. Otherwise `par64_oe` follows the same rules as `par_oe`.
- R8: While `rst_n` = 0, the outputs `par`, `par64`, `par_oe` and `par64_oe` are all 0.
- R9: Two events end a transaction and return the tracker to `ST_IDLE`. One is completion with `frame_n` = 1. The other is `irdy_n` = 1 while `frame_n` = 1. A `frame_n` = 0 in the very next clock is then treated as a new address phase (back-to-back).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad | input | 64 | Address/data value being driven on the bus |
| cbe_n | input | 8 | Command/byte-enable value being driven (active low) |
| frame_n | input | 1 | Transaction strobe, 0 = asserted |
| irdy_n | input | 1 | Initiator ready, 0 = asserted |
| trdy_n | input | 1 | Target ready, 0 = asserted |
| is_master | input | 1 | 1 = this block's side is the bus master |
| is_write | input | 1 | 1 = current transaction writes |
| mode32 | input | 1 | 1 = 32-bit bus strap, high lane unused |
| par | output | 1 | Low-lane even parity |
| par64 | output | 1 | High-lane even parity |
| par_oe | output | 1 | Drive enable for `par` |
| par64_oe | output | 1 | Drive enable for `par64` |

## Verification
The embedded assertions check the following on every cycle:
- The even-parity relation of each lane against the previous clock's bus values.
- That the 32-bit strap always silences the high enable.
- That an idle bus, or a target during an address phase, never drives.
- That a master writing with its ready asserted always drives on the next clock.

Some behaviours depend on transaction order, and only the bench's scenarios show them:
- The one-clock release after the final phase.
- Back-to-back address phases directly after completion.
- Master-read hand-off, where the address parity is driven once and then released.
- Wait states inserted by either side.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FINAL = 2'd2
    } bpg_state_e;
endpackage

// File: rtl/bpg_lane_par.sv
module bpg_lane_par #(
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data,
    input  logic [BW-1:0] be_n,
    output logic          par_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= 1'b0;
        else        par_q <= ^{data, be_n};
    end

    // R1
    lane_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((^{$past(data), $past(be_n), par_q}) == 1'b0));
endmodule

// File: rtl/bpg_phase_fsm.sv
module bpg_phase_fsm
    import bpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic is_master,
    input  logic is_write,
    input  logic mode32,
    output logic drive_lo,
    output logic drive_hi
);
    bpg_state_e state_q, state_d;

    logic done;
    assign done = !irdy_n && !trdy_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!frame_n) state_d = ST_BURST;
            ST_BURST: if (frame_n)  state_d = done ? ST_IDLE : (irdy_n ? ST_IDLE : ST_FINAL);
            ST_FINAL: if (done || irdy_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic want;
    always_comb begin
        want = 1'b0;
        unique case (state_q)
            ST_IDLE:  want = !frame_n && is_master;
            ST_BURST,
            ST_FINAL: want = (is_master && is_write && !irdy_n) ||
                             (!is_master && !is_write && !trdy_n);
            default:  want = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_lo <= 1'b0;
            drive_hi <= 1'b0;
        end else begin
            drive_lo <= want;
            drive_hi <= want && !mode32;
        end
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && frame_n) |=> (!drive_lo && !drive_hi));
    // R6
    target_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !is_master) |=> !drive_lo);
    // R4
    master_write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && is_master && is_write && !irdy_n) |=> drive_lo);
    // R3
    addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_n && is_master) |=> drive_lo);
endmodule

// File: rtl/bus_parity_gen.sv
module bus_parity_gen #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   ad,
    input  logic [DATA_W/8-1:0] cbe_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic                trdy_n,
    input  logic                is_master,
    input  logic                is_write,
    input  logic                mode32,
    output logic                par,
    output logic                par64,
    output logic                par_oe,
    output logic                par64_oe
);
    localparam int NLANE  = DATA_W / LANE_W;
    localparam int LANE_B = LANE_W / 8;

    logic [NLANE-1:0] lane_par;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        bpg_lane_par #(.DW(LANE_W), .BW(LANE_B)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .data  (ad[g*LANE_W +: LANE_W]),
            .be_n  (cbe_n[g*LANE_B +: LANE_B]),
            .par_q (lane_par[g])
        );
    end

    assign par   = lane_par[0];
    assign par64 = lane_par[NLANE-1];

    bpg_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .is_master (is_master),
        .is_write  (is_write),
        .mode32    (mode32),
        .drive_lo  (par_oe),
        .drive_hi  (par64_oe)
    );

    // R7
    strap_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode32 |=> !par64_oe);
    // R2
    hi_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((^{$past(ad[DATA_W-1:LANE_W]), $past(cbe_n[DATA_W/8-1:LANE_B]), par64}) == 1'b0));
endmodule

// File: tb/bus_parity_gen_tb.sv
module bus_parity_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad = '0;
    logic [7:0]  cbe_n = '1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        is_master = 1'b0, is_write = 1'b0, mode32 = 1'b0;
    logic        par, par64, par_oe, par64_oe;

    int tests = 0;
    int fails = 0;
    string scen = "R8";

    always #5 clk = ~clk;

    bus_parity_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .is_master(is_master), .is_write(is_write), .mode32(mode32),
        .par(par), .par64(par64), .par_oe(par_oe), .par64_oe(par64_oe)
    );

    // behavioural reference
    bit m_busy = 0;
    bit e_par = 0, e_par64 = 0, e_oe = 0, e_oe64 = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; e_par <= 0; e_par64 <= 0; e_oe <= 0; e_oe64 <= 0;
        end else begin
            bit drv;
            e_par   <= ($countones({ad[31:0],  cbe_n[3:0]}) % 2) == 1;
            e_par64 <= ($countones({ad[63:32], cbe_n[7:4]}) % 2) == 1;
            if (!m_busy) begin
                drv = (frame_n == 0) && is_master;
                m_busy <= (frame_n == 0);
            end else begin
                drv = (is_master && is_write && irdy_n == 0) ||
                      (!is_master && !is_write && trdy_n == 0);
                if (frame_n == 1 && (irdy_n == 1 || trdy_n == 0)) m_busy <= 0;
            end
            e_oe   <= drv;
            e_oe64 <= drv && !mode32;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual %b expected %b at %0t", tag, scen, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R1 par", par, e_par);
            chk("R2 par64", par64, e_par64);
            chk("R3/R4/R5/R6 par_oe", par_oe, e_oe);
            chk("R7 par64_oe", par64_oe, e_oe64);
        end
    end

    task automatic step(input logic f, input logic i, input logic t);
        @(negedge clk);
        frame_n = f; irdy_n = i; trdy_n = t;
        ad = {$urandom, $urandom};
        cbe_n = 8'($urandom);
    endtask

    // address phase, then nph data phases, each with waits target-wait cycles
    task automatic txn(input bit m, input bit w, input int nph, input int waits, input bit b2b);
        is_master = m; is_write = w;
        step(0, 1, 1);
        for (int p = 0; p < nph; p++) begin
            bit last = (p == nph - 1);
            for (int k = 0; k < waits; k++) step(last, 0, 1);
            step(last, 0, 0);
        end
        if (!b2b) begin
            step(1, 1, 1);
            step(1, 1, 1);
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        scen = "R8";
        chk("R8 par", par, 1'b0);
        chk("R8 par64", par64, 1'b0);
        chk("R8 par_oe", par_oe, 1'b0);
        chk("R8 par64_oe", par64_oe, 1'b0);
        @(negedge clk); rst_n = 1;
        scen = "R1 idle";   for (int k = 0; k < 6; k++) step(1, 1, 1);
        scen = "R4 mwrite"; txn(1, 1, 3, 1, 0);
        scen = "R3 mread";  txn(1, 0, 2, 2, 0);
        scen = "R5 sread";  txn(0, 0, 3, 2, 0);
        scen = "R6 swrite"; txn(0, 1, 2, 1, 0);
        mode32 = 1;
        scen = "R7 m32";    txn(1, 1, 2, 0, 0);
        txn(0, 0, 2, 1, 0);
        mode32 = 0;
        scen = "R9 b2b";    txn(1, 1, 2, 0, 1);
        txn(1, 1, 1, 1, 1);
        txn(0, 0, 2, 0, 0);
        scen = "R9 abort";  is_master = 1; is_write = 0;
        step(0, 1, 1); step(1, 1, 1); step(0, 1, 1); step(1, 0, 0); step(1, 1, 1);
        scen = "R1 mix";
        for (int n = 0; n < 20; n++) txn(n[0], n[1], 1 + n % 3, n % 2, n[2]);
        step(1, 1, 1); step(1, 1, 1);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule